// File: doc/BRIEF.md
# Square-Run Word Recognizer Array

This block decides, one symbol per clock, whether an incoming word consists of a run of `a` symbols whose length is a perfect square n² (n ≥ 1), followed by exactly 2n−1 `b` symbols. It is built as a linear chain of identical small cells with a leftmost control cell. Only the control cell sees the input stream. It raises either an accept flag or a reject flag, and the flag stays set until reset.

No cell holds an arithmetic counter. The control cell sends a pulse into the chain. The pulse runs right through the cells already claimed, claims the first free cell and comes back. A trip launched after k² `a` symbols returns exactly in time for the (k+1)²-th `a`, so perfect squares are recognised from the timing of the trip alone. The trip launched by the last square `a` also measures the `b` run: it returns exactly on the cycle that must carry the end marker. When the decision is made, a freeze wave moves right one cell per clock, and every cell it reaches keeps its state from then on.

Top module: `iar_square_recognizer`

## Requirements
- R1: While reset is asserted, and after reset until a decision is made, both `accept_o` and `reject_o` are 0.
- R2: The first rising edge after reset is released consumes the first symbol, and each later edge consumes one more. The input code 2'b01 is `a` and 2'b10 is `b`. Both 2'b00 and 2'b11 mean end of input.
- R3: A word a^(n²) b^(2n−1) with n ≥ 1 is accepted: `accept_o` rises right after the edge that consumes the end marker.
- R4: If the first symbol is `b` or end of input, `reject_o` rises right after the edge that consumes it.
- R5: An `a` that follows a `b` causes a reject right after the edge that consumes that `a`.
- R6: If the run of `a` symbols is not a perfect square, the word is rejected on the edge that consumes the first `b`. A word made only of `a` symbols is rejected on the edge that consumes its end marker.
- R7: With n² `a` symbols and fewer than 2n−1 `b` symbols, the word is rejected on the edge that consumes the end marker.
- R8: With n² `a` symbols, the word is rejected on the edge that consumes the 2n-th `b`.
- R9: Once a flag is set, both flags keep their values whatever symbols follow, until reset.
- R10: With N_CELLS cells, words with up to (N_CELLS+1)²−1 `a` symbols are decided correctly. This includes acceptance for n = N_CELLS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every rising edge consumes one symbol |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_i | input | 2 | Input symbol: 01 = a, 10 = b, 00 or 11 = end of input |
| accept_o | output | 1 | Sticky accept flag |
| reject_o | output | 1 | Sticky reject flag |

## Verification
Two things can fall in the same cycle at the control cell: the return of the square-timing pulse and the consumption of a `b` or of the end marker. Which of the two coincides decides accept (pulse meets the end marker), too many `b`s (pulse meets a `b`) or too few (end marker arrives before the pulse). The sweep varies the `b` count across 2n−2, 2n−1, 2n and beyond for every square and non-square `a` count within reach, so that the pulse lands on each kind of symbol. For every cycle the bench computes arithmetically in which cycle a decision is due and which flag must show it.

// File: rtl/iar_pkg.sv
package iar_pkg;

   typedef enum logic [1:0] {
      SYM_END = 2'b00,
      SYM_A   = 2'b01,
      SYM_B   = 2'b10,
      SYM_RSV = 2'b11
   } sym_e;

   typedef enum logic [2:0] {
      CS_IDLE = 3'd0,
      CS_APH  = 3'd1,
      CS_BPH  = 3'd2,
      CS_ACC  = 3'd3,
      CS_REJ  = 3'd4
   } comm_st_e;

   typedef struct packed {
      logic claimed;
      logic go_r;
      logic ret_l;
      logic frz;
   } cell_st_t;

endpackage

// File: rtl/iar_comm_cell.sv
module iar_comm_cell
   import iar_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] sym_i,
   input  logic       ret_i,
   output logic       fwd_o,
   output logic       frz_o,
   output logic       accept_o,
   output logic       reject_o
);

   comm_st_e st_q, st_d;
   logic     pend_q, pend_d;
   logic     lastsq_q, lastsq_d;
   logic     launch_q, launch_d;
   logic     is_a, is_b, is_end;

   assign is_a   = (sym_i == SYM_A);
   assign is_b   = (sym_i == SYM_B);
   assign is_end = !is_a && !is_b;

   always_comb begin
      st_d     = st_q;
      pend_d   = pend_q | ret_i;
      lastsq_d = lastsq_q;
      launch_d = 1'b0;
      unique case (st_q)
         CS_IDLE: begin
            if (is_a) begin
               st_d     = CS_APH;
               launch_d = 1'b1;
               lastsq_d = 1'b1;
               pend_d   = 1'b0;
            end else begin
               st_d = CS_REJ;
            end
         end
         CS_APH: begin
            if (is_a) begin
               if (pend_q) begin
                  launch_d = 1'b1;
                  lastsq_d = 1'b1;
                  pend_d   = 1'b0;
               end else begin
                  lastsq_d = 1'b0;
               end
            end else if (is_b) begin
               st_d = lastsq_q ? CS_BPH : CS_REJ;
            end else begin
               st_d = CS_REJ;
            end
         end
         CS_BPH: begin
            if (is_a) begin
               st_d = CS_REJ;
            end else if (is_b) begin
               if (ret_i) st_d = CS_REJ;
            end else begin
               st_d = ret_i ? CS_ACC : CS_REJ;
            end
         end
         CS_ACC:  st_d = CS_ACC;
         CS_REJ:  st_d = CS_REJ;
         default: st_d = CS_REJ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= CS_IDLE;
         pend_q   <= 1'b0;
         lastsq_q <= 1'b0;
         launch_q <= 1'b0;
      end else begin
         st_q     <= st_d;
         pend_q   <= pend_d;
         lastsq_q <= lastsq_d;
         launch_q <= launch_d;
      end
   end

   assign fwd_o    = launch_q;
   assign frz_o    = (st_q == CS_ACC) || (st_q == CS_REJ);
   assign accept_o = (st_q == CS_ACC);
   assign reject_o = (st_q == CS_REJ);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_o || reject_o) |=> ($stable(accept_o) && $stable(reject_o)));

   p_first_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == CS_IDLE && sym_i == SYM_B) |=> reject_o);

   p_a_after_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == CS_BPH && sym_i == SYM_A) |=> reject_o);

   p_too_many_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == CS_BPH && sym_i == SYM_B && ret_i) |=> reject_o);

   p_accept_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(accept_o) |-> ($past(sym_i) != SYM_A && $past(sym_i) != SYM_B && $past(ret_i)));

endmodule

// File: rtl/iar_cell.sv
module iar_cell
   import iar_pkg::*;
#(
   parameter bit FREEZE_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic left_fwd_i,
   input  logic left_frz_i,
   input  logic right_bk_i,
   output logic fwd_o,
   output logic bk_o,
   output logic frz_o
);

   cell_st_t q, step_d, d;
   logic     hold;

   generate
      if (FREEZE_EN) begin : g_frz
         assign hold = q.frz;
      end else begin : g_nofrz
         assign hold = 1'b0;
      end
   endgenerate

   always_comb begin
      step_d.claimed = q.claimed | left_fwd_i;
      step_d.go_r    = left_fwd_i & q.claimed;
      step_d.ret_l   = (left_fwd_i & ~q.claimed) | right_bk_i;
      step_d.frz     = q.frz | left_frz_i;
      if (hold) begin
         d = q;
      end else begin
         d = step_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         q <= d;
      end
   end

   assign fwd_o = q.go_r;
   assign bk_o  = q.ret_l;
   assign frz_o = q.frz;

   p_sig_in_region_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (q.go_r || q.ret_l) |-> q.claimed);

   p_claim_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      q.claimed |=> q.claimed);

   p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (FREEZE_EN && q.frz) |=> ($stable(q.claimed) && $stable(q.ret_l) && $stable(q.go_r)));

endmodule

// File: rtl/iar_square_recognizer.sv
module iar_square_recognizer
   import iar_pkg::*;
#(
   parameter int N_CELLS   = 8,
   parameter bit FREEZE_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] sym_i,
   output logic       accept_o,
   output logic       reject_o
);

   localparam int MAX_A = (N_CELLS + 1) * (N_CELLS + 1) - 1;

   generate
      if (N_CELLS < 1) begin : g_bad_n
         $error("iar_square_recognizer: N_CELLS must be at least 1");
      end
      if (MAX_A < 3) begin : g_bad_reach
         $error("iar_square_recognizer: reach too small");
      end
   endgenerate

   logic [N_CELLS:0]   fwd;
   logic [N_CELLS:0]   frz;
   logic [N_CELLS+1:1] bk;

   iar_comm_cell u_comm (
      .clk      (clk),
      .rst_n    (rst_n),
      .sym_i    (sym_i),
      .ret_i    (bk[1]),
      .fwd_o    (fwd[0]),
      .frz_o    (frz[0]),
      .accept_o (accept_o),
      .reject_o (reject_o)
   );

   assign bk[N_CELLS+1] = 1'b0;

   generate
      for (genvar gi = 1; gi <= N_CELLS; gi++) begin : g_cell
         iar_cell #(.FREEZE_EN(FREEZE_EN)) u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .left_fwd_i (fwd[gi-1]),
            .left_frz_i (frz[gi-1]),
            .right_bk_i (bk[gi+1]),
            .fwd_o      (fwd[gi]),
            .bk_o       (bk[gi]),
            .frz_o      (frz[gi])
         );
      end
   endgenerate

   p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({accept_o, reject_o}));

   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |-> (!accept_o && !reject_o));

endmodule

// File: tb/tb_iar_square_recognizer.sv
module tb_iar_square_recognizer;
   import iar_pkg::*;

   localparam int NC    = 4;
   localparam int MAX_A = (NC + 1) * (NC + 1) - 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] sym_i = SYM_END;
   logic       accept_o, reject_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   iar_square_recognizer #(.N_CELLS(NC), .FREEZE_EN(1'b1)) dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .sym_i    (sym_i),
      .accept_o (accept_o),
      .reject_o (reject_o)
   );

   function automatic int isqrt(input int v);
      int r = 0;
      while ((r + 1) * (r + 1) <= v) r++;
      return r;
   endfunction

   function automatic logic [1:0] sym_at(input int t, input int na, input int nb,
                                         input int na2, input logic [1:0] endc);
      if (t <= na) return SYM_A;
      if (t <= na + nb) return SYM_B;
      if (t <= na + nb + na2) return SYM_A;
      if (t == na + nb + na2 + 1) return endc;
      return (t % 2 == 1) ? SYM_A : SYM_B;
   endfunction

   task automatic check(input bit ea, input bit er, input string req);
      checks++;
      if (accept_o !== ea || reject_o !== er) begin
         errors++;
         $display("FAIL %s: accept/reject actual %b%b expected %b%b", req,
                  accept_o, reject_o, ea, er);
      end
   endtask

   task automatic run_word(input int na, input int nb, input int na2, input logic [1:0] endc);
      int  dedge = 0;
      bit  acc = 0;
      string tag = "";
      int  ca = 0, cb = 0;
      int  len = na + nb + na2;
      // expected decision from the requirements
      for (int t = 1; t <= len + 1 && dedge == 0; t++) begin
         logic [1:0] s = sym_at(t, na, nb, na2, endc);
         if (s == SYM_A) begin
            if (cb > 0) begin dedge = t; tag = "R5"; end
            else ca++;
         end else if (s == SYM_B) begin
            if (ca == 0) begin dedge = t; tag = "R4"; end
            else if (cb == 0 && isqrt(ca) * isqrt(ca) != ca) begin dedge = t; tag = "R6"; end
            else begin
               cb++;
               if (cb == 2 * isqrt(ca)) begin dedge = t; tag = "R8"; end
            end
         end else begin
            dedge = t;
            if (ca == 0) tag = "R4";
            else if (cb == 0) tag = "R6";
            else if (cb == 2 * isqrt(ca) - 1) begin acc = 1; tag = "R3"; end
            else tag = "R7";
         end
      end
      if (acc && isqrt(ca) == NC) tag = "R3 R10";
      if (endc == SYM_RSV && dedge == len + 1) tag = {tag, " R2"};

      @(negedge clk);
      rst_n = 1'b0;
      sym_i = sym_at(1, na, nb, na2, endc);
      repeat (2) @(negedge clk);
      check(1'b0, 1'b0, "R1");
      rst_n = 1'b1;
      for (int t = 1; t <= dedge + 3; t++) begin
         @(negedge clk);
         if (t < dedge) check(1'b0, 1'b0, "R1 R2");
         else if (t == dedge) check(acc, !acc, tag);
         else check(acc, !acc, "R9");
         sym_i = sym_at(t + 1, na, nb, na2, endc);
      end
   endtask

   initial begin
      for (int na = 0; na <= MAX_A; na++) begin
         for (int nb = 0; nb <= 10; nb++) begin
            for (int na2 = 0; na2 <= 1; na2++) begin
               if (na + na2 <= MAX_A) begin
                  run_word(na, nb, na2, ((na + nb) % 3 == 0) ? SYM_RSV : SYM_END);
               end
            end
         end
      end
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #4000000;
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule